// File: doc/BRIEF.md
# 4x4 Matrix Keypad Scanner

This block reads a sixteen-key switch matrix built from four column lines that it drives and four return lines that it reads back. Every line idles high. A closed key joins its column to its row, so a row reads low only while its column is driven low. The block drives all columns low and waits until every return line reads high, which means no key is held. It then lets a settling interval pass and waits for any closure. A closure is accepted only if it is still present after a second settling interval. The block then drives one column low at a time to find the key, and reports it once as an ASCII hexadecimal digit with a single-cycle strobe.

The return lines pass through a synchroniser before any decision is made. After each change of column drive the block also waits for the lines to settle, so a scan step always reads the response to the column pattern it has just driven. The settling interval is a clock-count parameter. If several keys are down, the first key in scan order is taken.

Top module: `keypad_matrix_scanner`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `col_drv_n` is 4'b0000, `key_strobe` is 0 and `key_char` is 8'h00.
- R2: A report needs a release first. With all columns driven low, all four return lines must read high before a closure is accepted. A key held from reset onward is never reported until it has been released and pressed again.
- R3: A closure is accepted only if at least one return line still reads low after `DEBOUNCE_CYC` cycles. A closure that is gone by then is dropped without a report, and the block goes back to waiting for a closure.
- R4: Outside a scan all four columns are driven low. A scan drives `col_drv_n` through 4'b1110, 4'b1101, 4'b1011, 4'b0111, one pattern per step, with exactly one column low at any time. After the scan the columns return to 4'b0000.
- R5: A key on column c (bit c of `col_drv_n`) and return line r (bit r of `row_in_n`) has index 4*c+r. Indices 0 to 9 are reported as 8'h30+index. Indices 10 to 15 are reported as 8'h41+(index-10).
- R6: Each accepted press gives exactly one `key_strobe` pulse, one cycle long. Holding the key, or pressing more keys while it is held, gives no further report until all keys are released.
- R7: With several keys closed, the lowest column that has a closure wins. Within that column, the lowest return line wins.
- R8: `key_char` keeps the last reported code, unchanged in every cycle without a strobe, until the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_drv_n | output | 4 | Column drive, a 0 activates that column |
| row_in_n | input | 4 | Return lines, pulled high, 0 means a closed key in an active column |
| key_char | output | 8 | ASCII hexadecimal character of the last reported key |
| key_strobe | output | 1 | One-cycle pulse marking a new report on `key_char` |

## Verification
Two functions meet in one cycle: the report and the return to the release check. On the edge that raises `key_strobe`, the columns also switch back to all-low while the key is still physically closed. The bench provokes this by holding a key for hundreds of cycles after its strobe and then closing a second key in another column. It counts a pass only if no second strobe appears and `col_drv_n` stays at 4'b0000. It also logs every column pattern around the scan that finds key 15, to confirm that the scan steps and the return to all-low come in the required order.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int KP_COLS  = 4;
    localparam int KP_ROWS  = 4;
    localparam int KP_COL_W = $clog2(KP_COLS);
    localparam int KP_ROW_W = $clog2(KP_ROWS);
    localparam int KP_KEY_W = KP_COL_W + KP_ROW_W;
    localparam int KP_DIGITS = 10;

    typedef enum logic [2:0] {
        ST_RELEASE  = 3'd0,
        ST_REL_DB   = 3'd1,
        ST_IDLE     = 3'd2,
        ST_PRESS_DB = 3'd3,
        ST_CONFIRM  = 3'd4,
        ST_SCAN     = 3'd5
    } scan_state_t;

    typedef struct packed {
        logic                hit;
        logic [KP_ROW_W-1:0] row;
    } row_hit_t;

    typedef struct packed {
        logic       fire;
        logic [7:0] code;
    } key_evt_t;

    // Lowest-numbered return line that reads low wins.
    function automatic row_hit_t first_low_row(input logic [KP_ROWS-1:0] rows_n);
        row_hit_t res;
        res = '0;
        for (int i = KP_ROWS - 1; i >= 0; i--) begin
            if (!rows_n[i]) begin
                res.hit = 1'b1;
                res.row = KP_ROW_W'(i);
            end
        end
        return res;
    endfunction

    // Key index to ASCII hexadecimal digit.
    function automatic logic [7:0] key_to_ascii(input logic [KP_KEY_W-1:0] idx);
        logic [7:0] wide;
        wide = 8'(idx);
        if (wide < 8'(KP_DIGITS)) begin
            return 8'h30 + wide;
        end
        return 8'h41 + (wide - 8'(KP_DIGITS));
    endfunction

    // Single-zero column drive pattern for a given column.
    function automatic logic [KP_COLS-1:0] col_pattern(input logic [KP_COL_W-1:0] idx);
        logic [KP_COLS-1:0] p;
        p = '1;
        p[idx] = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic [31:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[0] <= WIDTH'(RESET_VAL);
                end else begin
                    stage_q[0] <= d;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= {STAGES{WIDTH'(RESET_VAL)}};
                end else begin
                    stage_q <= {stage_q[STAGES-2:0], d};
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/kpd_timer.sv
module kpd_timer #(
    parameter int          CW       = 4,
    parameter int unsigned INIT_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(INIT_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == '0);

    // R3: a running interval counts down by one each cycle
    p_tmr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R3: a load starts the interval from the requested value
    p_tmr_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/kpd_ctrl.sv
module kpd_ctrl
    import kpd_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 16,
    parameter int SETTLE_CYC   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [KP_ROWS-1:0] rows_n,
    output logic [KP_COLS-1:0] col_drv_n,
    output logic [7:0]         key_char,
    output logic               key_strobe
);

    localparam int TMAX     = (DEBOUNCE_CYC > SETTLE_CYC) ? DEBOUNCE_CYC : SETTLE_CYC;
    localparam int CW       = $clog2(TMAX + 1);
    localparam int DEB_LD_I = (DEBOUNCE_CYC > 1) ? DEBOUNCE_CYC - 1 : 1;
    localparam int SET_LD_I = (SETTLE_CYC > 1) ? SETTLE_CYC - 1 : 1;
    localparam logic [CW-1:0] DEB_LD = CW'(DEB_LD_I);
    localparam logic [CW-1:0] SET_LD = CW'(SET_LD_I);
    localparam logic [KP_COL_W-1:0] COL_LAST = KP_COL_W'(KP_COLS - 1);

    scan_state_t         state_q, state_d;
    logic [KP_COL_W-1:0] col_q, col_d;
    logic                tmr_load;
    logic [CW-1:0]       tmr_val;
    logic                tmr_done;
    logic                any_closed;
    row_hit_t            hit;
    key_evt_t            evt;

    kpd_timer #(
        .CW       (CW),
        .INIT_VAL (SET_LD_I)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign any_closed = ~&rows_n;
    assign hit        = first_low_row(rows_n);

    always_comb begin
        state_d  = state_q;
        col_d    = col_q;
        tmr_load = 1'b0;
        tmr_val  = SET_LD;
        evt      = '0;
        unique case (state_q)
            ST_RELEASE: begin
                if (tmr_done && !any_closed) begin
                    state_d  = ST_REL_DB;
                    tmr_load = 1'b1;
                    tmr_val  = DEB_LD;
                end
            end
            ST_REL_DB: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (any_closed) begin
                    state_d  = ST_PRESS_DB;
                    tmr_load = 1'b1;
                    tmr_val  = DEB_LD;
                end
            end
            ST_PRESS_DB: begin
                if (tmr_done) begin
                    state_d = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (any_closed) begin
                    state_d  = ST_SCAN;
                    col_d    = '0;
                    tmr_load = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SCAN: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (hit.hit) begin
                        evt.fire = 1'b1;
                        evt.code = key_to_ascii({col_q, hit.row});
                        state_d  = ST_RELEASE;
                    end else if (col_q == COL_LAST) begin
                        state_d = ST_RELEASE;
                    end else begin
                        col_d = col_q + KP_COL_W'(1);
                    end
                end
            end
            default: begin
                state_d  = ST_RELEASE;
                tmr_load = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RELEASE;
            col_q      <= '0;
            col_drv_n  <= '0;
            key_strobe <= 1'b0;
            key_char   <= 8'h00;
        end else begin
            state_q    <= state_d;
            col_q      <= col_d;
            col_drv_n  <= (state_d == ST_SCAN) ? col_pattern(col_d) : '0;
            key_strobe <= evt.fire;
            if (evt.fire) begin
                key_char <= evt.code;
            end
        end
    end

    // R2: the release check passes only on all-high lines under all-low columns
    p_release_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REL_DB && $past(state_q) == ST_RELEASE)
            |-> ($past(rows_n) == '1 && $past(col_drv_n) == '0));

    // R3: a scan is only entered from the confirmation step
    p_scan_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && $past(state_q) != ST_SCAN)
            |-> ($past(state_q) == ST_CONFIRM));

    // R4: column drive is all-low or has exactly one low column
    p_col_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (col_drv_n == '0) || ($countones(col_drv_n) == KP_COLS - 1));

    // R4: successive scan patterns move the zero up one column
    p_col_rotate_r4: assert property (@(posedge clk) disable iff (rst)
        (col_drv_n != '0 && $past(col_drv_n) != '0 && col_drv_n != $past(col_drv_n))
            |-> (col_drv_n == {$past(col_drv_n[KP_COLS-2:0]), $past(col_drv_n[KP_COLS-1])}));

    // R5: a report always carries a legal hexadecimal character
    p_char_legal_r5: assert property (@(posedge clk) disable iff (rst)
        key_strobe |-> ((key_char >= 8'h30 && key_char <= 8'h39) ||
                        (key_char >= 8'h41 && key_char <= 8'h46)));

endmodule

// File: rtl/keypad_matrix_scanner.sv
module keypad_matrix_scanner
    import kpd_pkg::*;
#(
    parameter int DEBOUNCE_CYC = 50000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst,
    output logic [3:0]   col_drv_n,
    input  logic [3:0]   row_in_n,
    output logic [7:0]   key_char,
    output logic         key_strobe
);

    localparam int SETTLE_CYC = SYNC_STAGES + 1;

    logic [KP_ROWS-1:0] rows_sync_n;

    kpd_sync #(
        .WIDTH     (KP_ROWS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('1)
    ) u_row_sync (
        .clk (clk),
        .rst (rst),
        .d   (row_in_n),
        .q   (rows_sync_n)
    );

    kpd_ctrl #(
        .DEBOUNCE_CYC (DEBOUNCE_CYC),
        .SETTLE_CYC   (SETTLE_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rows_n     (rows_sync_n),
        .col_drv_n  (col_drv_n),
        .key_char   (key_char),
        .key_strobe (key_strobe)
    );

    // R1: reset leaves all columns low and no report
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (col_drv_n == '0 && !key_strobe && key_char == 8'h00));

    // R6: the report strobe lasts a single cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        key_strobe |=> !key_strobe);

    // R8: the character only changes together with a strobe
    p_char_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !key_strobe |-> $stable(key_char));

endmodule

// File: tb/keypad_matrix_scanner_tb.sv
module keypad_matrix_scanner_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEB_CYC    = 16;

    typedef struct packed {
        logic [15:0] mask;
        logic [7:0]  exp;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0001, 8'h30}, '{16'h0002, 8'h31}, '{16'h0004, 8'h32}, '{16'h0008, 8'h33},
        '{16'h0010, 8'h34}, '{16'h0020, 8'h35}, '{16'h0040, 8'h36}, '{16'h0080, 8'h37},
        '{16'h0100, 8'h38}, '{16'h0200, 8'h39}, '{16'h0400, 8'h41}, '{16'h0800, 8'h42},
        '{16'h1000, 8'h43}, '{16'h2000, 8'h44}, '{16'h4000, 8'h45}, '{16'h8000, 8'h46},
        '{16'h0024, 8'h32}, '{16'h000A, 8'h31}, '{16'hC000, 8'h45}, '{16'h8100, 8'h38}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] key_mask = '0;
    logic [3:0]  row_n;
    logic [3:0]  col_n;
    logic [7:0]  key_char;
    logic        key_strobe;

    int checks = 0;
    int failures = 0;
    int strobe_cnt = 0;
    int double_pulse = 0;
    logic [7:0] last_char = 8'h00;
    logic       prev_strobe = 1'b0;
    logic [3:0] seq_log [64];
    int         seq_total = 0;
    logic [3:0] col_prev = 4'h0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keypad_matrix_scanner #(
        .DEBOUNCE_CYC (DEB_CYC),
        .SYNC_STAGES  (2)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .col_drv_n  (col_n),
        .row_in_n   (row_n),
        .key_char   (key_char),
        .key_strobe (key_strobe)
    );

    // Switch matrix model: a closed key pulls its row low when its column is low.
    always_comb begin
        row_n = 4'hF;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                if (key_mask[c*4 + r] && !col_n[c]) begin
                    row_n[r] = 1'b0;
                end
            end
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (key_strobe === 1'b1) begin
            strobe_cnt = strobe_cnt + 1;
            last_char  = key_char;
            if (prev_strobe) double_pulse = double_pulse + 1;
        end
        prev_strobe = (key_strobe === 1'b1);
        if (col_n !== col_prev) begin
            seq_log[seq_total % 64] = col_n;
            seq_total = seq_total + 1;
            col_prev  = col_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_strobe(input int base);
        for (int i = 0; i < 400 && strobe_cnt == base; i++) @(negedge clk);
    endtask

    task automatic press_expect(input logic [15:0] m, input logic [7:0] exp, input string tag);
        int base;
        key_mask = '0;
        repeat (60) @(negedge clk);
        base = strobe_cnt;
        key_mask = m;
        wait_strobe(base);
        repeat (3) @(negedge clk);
        check(strobe_cnt == base + 1, tag, strobe_cnt - base, 1);
        check(last_char == exp, tag, int'(last_char), int'(exp));
        key_mask = '0;
        repeat (60) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        logic [3:0] exp_seq [5];
        exp_seq = '{4'hE, 4'hD, 4'hB, 4'h7, 4'h0};

        // R1 and R2: key 7 is held across reset.
        rst = 1'b1;
        key_mask = 16'h0080;
        repeat (5) @(negedge clk);
        check(col_n == 4'h0, "R1 col", int'(col_n), 0);
        check(key_strobe == 1'b0, "R1 strobe", int'(key_strobe), 0);
        check(key_char == 8'h00, "R1 char", int'(key_char), 0);
        rst = 1'b0;
        repeat (200) @(negedge clk);
        check(strobe_cnt == 0, "R2 held-from-reset", strobe_cnt, 0);
        check(col_n == 4'h0, "R2 columns", int'(col_n), 0);
        press_expect(16'h0080, 8'h37, "R2 re-press");

        // R5 single keys, R7 multiple keys.
        for (int v = 0; v < NVEC; v++) begin
            press_expect(VECS[v].mask, VECS[v].exp, (v < 16) ? "R5 map" : "R7 priority");
        end

        // R4: column sequence for a key in the last column.
        base = seq_total;
        press_expect(16'h8000, 8'h46, "R4 key");
        check(seq_total - base == 5, "R4 steps", seq_total - base, 5);
        for (int k = 0; k < 5; k++) begin
            check(seq_log[(base + k) % 64] == exp_seq[k], "R4 pattern",
                  int'(seq_log[(base + k) % 64]), int'(exp_seq[k]));
        end

        // R3: a closure shorter than the interval is dropped.
        repeat (60) @(negedge clk);
        base = strobe_cnt;
        key_mask = 16'h0008;
        repeat (5) @(negedge clk);
        key_mask = '0;
        repeat (150) @(negedge clk);
        check(strobe_cnt == base, "R3 glitch", strobe_cnt - base, 0);
        check(col_n == 4'h0, "R3 columns", int'(col_n), 0);
        press_expect(16'h0008, 8'h33, "R3 steady");

        // R6: hold, then add a second key, without release.
        repeat (60) @(negedge clk);
        base = strobe_cnt;
        key_mask = 16'h0400;
        wait_strobe(base);
        repeat (300) @(negedge clk);
        check(strobe_cnt == base + 1, "R6 hold", strobe_cnt - base, 1);
        key_mask = 16'h0408;
        repeat (200) @(negedge clk);
        check(strobe_cnt == base + 1, "R6 added key", strobe_cnt - base, 1);
        check(col_n == 4'h0, "R6 columns", int'(col_n), 0);
        key_mask = '0;
        repeat (60) @(negedge clk);
        check(double_pulse == 0, "R6 pulse width", double_pulse, 0);

        // R8: character held after release.
        check(key_char == 8'h41, "R8 hold", int'(key_char), 8'h41);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule